// File: doc/BRIEF.md
# Segment Buffer Cache with Masked Writeback

This block sits in front of a slow non-volatile memory array whose reads are non-destructive. A word-addressed request port reads and writes 32-bit words. The block answers these requests from a small set of narrow segment buffers. Each buffer holds one eight-word slice of a wide array row. On a miss, the block fetches only that slice. Writes that hit an open buffer are merged in place. A buffer that was never written is dropped on eviction without any array write. A buffer that holds writes sends back only its modified words, under a word-enable mask, in a single array transaction.

Victims are chosen in least-recently-used order. An invalid buffer is always taken before a valid one. A flush input writes back every buffer that holds modified words, in ascending buffer index, and then raises a one-cycle done pulse. Two running counters, array write transactions and array words written, let the surrounding system measure how much write coalescing and partial writeback save.

The controller is a single state machine with these states:
- `ST_IDLE`: accepts requests and serves hits.
- `ST_WB`: issues a masked writeback.
- `ST_FILL_REQ`: issues a segment read.
- `ST_FILL_WAIT`: waits for the read data.
- `ST_REPLAY`: performs the pending access on the freshly filled buffer.
- `ST_FL_SCAN`: looks for the lowest-index modified buffer.
- `ST_FL_DONE`: raises the done pulse.

Transitions:
- `ST_IDLE`→`ST_FL_SCAN` on flush.
- `ST_IDLE`→`ST_WB` on a miss whose victim holds modified words.
- `ST_IDLE`→`ST_FILL_REQ` on a miss whose victim is clean or invalid.
- `ST_WB`→`ST_FILL_REQ` on handshake during a miss.
- `ST_WB`→`ST_FL_SCAN` on handshake during a flush.
- `ST_FILL_REQ`→`ST_FILL_WAIT` on handshake.
- `ST_FILL_WAIT`→`ST_REPLAY` on read data.
- `ST_REPLAY`→`ST_IDLE`.
- `ST_FL_SCAN`→`ST_WB` when a modified buffer is found.
- `ST_FL_SCAN`→`ST_FL_DONE` when none is found.
- `ST_FL_DONE`→`ST_IDLE`.

Top module: `rbc_row_cache`

## Requirements
- R1: After reset, all buffers are invalid, `req_ready` is 1, `rsp_valid`, `arr_cmd_valid` and `flush_done` are 0, and both counters read 0.
- R2: The request address splits, from MSB to LSB, into a row field (6 bits), a segment field (5 bits) and a word offset (3 bits). The segment tag `{row, segment}` is bits 13:3. A miss issues exactly one array read, with `arr_cmd_we`=0, carrying that tag. The read returns word `offset` of the fetched slice, where word w occupies bits `w*32+31:w*32` of `arr_rsp_rdata`.
- R3: A read that hits issues no array command, and `rsp_valid` with the data is high in the cycle after the request is accepted.
- R4: A write updates byte b of the addressed word only when `req_strb[b]` is 1. The word becomes modified only when at least one strobe bit is set. A write with all strobes 0 leaves the data unchanged.
- R5: Evicting a buffer that holds no modified words issues no array write.
- R6: Any number of writes to one resident segment causes exactly one array write transaction, at its eviction. That transaction carries the latest data.
- R7: A writeback sets bit w of `arr_cmd_wmask` exactly when word w is modified. Words with a 0 mask bit are left unchanged in the array.
- R8: The victim is the lowest-index invalid buffer if there is one, and otherwise the least recently used buffer. Every hit and every fill makes that buffer the most recently used.
- R9: On a miss whose victim holds modified words, the writeback handshake completes before the fill read is issued. No request is accepted while an array command is pending.
- R10: A flush writes back the modified buffers in ascending index order and then raises `flush_done` for one cycle. A flush with nothing modified raises `flush_done` with no array write.
- R11: When `flush_req` and `req_valid` are high in the same cycle, the flush wins and `req_ready` is 0. The held request is accepted once the flush has completed.
- R12: `wr_txn_count` increases by 1 and `wr_word_count` by the number of mask bits set on each accepted array write. Neither counter changes at any other time.
- R13: While `arr_cmd_valid` is 1 and `arr_cmd_ready` is 0, the command fields are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 14 | Word address {row, segment, offset} |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte write strobe |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flush_req | input | 1 | Request to write back all modified buffers |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| arr_cmd_valid | output | 1 | Array command valid |
| arr_cmd_ready | input | 1 | Array accepts command |
| arr_cmd_we | output | 1 | 1 = masked segment write, 0 = segment read |
| arr_cmd_tag | output | 11 | Segment tag {row, segment} |
| arr_cmd_wdata | output | 256 | Segment write data |
| arr_cmd_wmask | output | 8 | Word-enable mask for the write |
| arr_rsp_valid | input | 1 | Segment read data valid |
| arr_rsp_rdata | input | 256 | Segment read data |
| wr_txn_count | output | 32 | Count of array write transactions |
| wr_word_count | output | 32 | Count of array words written |

## Verification
The flush input and a new request can arrive in the same cycle, and both compete for the idle controller. The bench raises `flush_req` and `req_valid` at the same clock edge. It checks that `req_ready` stays low, that exactly one `flush_done` pulse follows, and that the held read is served afterwards with the correct data. A second overlap is the writeback and the fill of one miss, which share the array port. Here the bench logs every array command and checks that the masked write for the victim comes immediately before the read for the new segment. It also checks that no command changes while the array stalls.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_REPLAY,
        ST_FL_SCAN,
        ST_FL_DONE
    } state_t;

endpackage

// File: rtl/rbc_match.sv
module rbc_match #(
    parameter int NBUF  = 4,
    parameter int TAG_W = 11,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]            valid,
    input  logic [NBUF-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           lookup,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx
);

    logic [NBUF-1:0] match;

    for (genvar i = 0; i < NBUF; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == lookup);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/rbc_lru.sv
module rbc_lru #(
    parameter int NBUF = 4,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [NBUF-1:0]  valid,
    output logic [IDX_W-1:0] victim
);

    // Ages form a permutation of 0..NBUF-1; 0 is most recent.
    logic [IDX_W-1:0] age_q [NBUF];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NBUF; j++) age_q[j] <= IDX_W'(j);
        end else if (touch_en) begin
            for (int j = 0; j < NBUF; j++) begin
                if (IDX_W'(j) == touch_idx)         age_q[j] <= '0;
                else if (age_q[j] < age_q[touch_idx]) age_q[j] <= age_q[j] + 1'b1;
            end
        end
    end

    logic             inv_found;
    logic [IDX_W-1:0] inv_idx, old_idx;

    always_comb begin
        inv_found = 1'b0;
        inv_idx   = '0;
        old_idx   = '0;
        for (int j = NBUF - 1; j >= 0; j--) begin
            if (!valid[j]) begin
                inv_found = 1'b1;
                inv_idx   = IDX_W'(j);
            end
            if (age_q[j] == IDX_W'(NBUF - 1)) old_idx = IDX_W'(j);
        end
        victim = inv_found ? inv_idx : old_idx;
    end

endmodule

// File: rtl/rbc_row_cache.sv
module rbc_row_cache
    import rbc_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int WORDS = 8,
    parameter int DW    = 32,
    parameter int ROW_W = 6,
    parameter int SEG_W = 5,
    parameter int CNT_W = 32,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ROW_W + SEG_W,
    localparam int ADDR_W = TAG_W + OFF_W,
    localparam int IDX_W  = $clog2(NBUF),
    localparam int SB     = DW / 8,
    localparam int SEGB   = WORDS * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    input  logic [SB-1:0]     req_strb,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              arr_cmd_valid,
    input  logic              arr_cmd_ready,
    output logic              arr_cmd_we,
    output logic [TAG_W-1:0]  arr_cmd_tag,
    output logic [SEGB-1:0]   arr_cmd_wdata,
    output logic [WORDS-1:0]  arr_cmd_wmask,
    input  logic              arr_rsp_valid,
    input  logic [SEGB-1:0]   arr_rsp_rdata,
    output logic [CNT_W-1:0]  wr_txn_count,
    output logic [CNT_W-1:0]  wr_word_count
);

    state_t state_q, state_d;

    logic [NBUF-1:0]             valid_q;
    logic [NBUF-1:0][TAG_W-1:0]  tag_q;
    logic [WORDS-1:0]            dirty_q [NBUF];
    logic [DW-1:0]               data_q  [NBUF][WORDS];

    logic [ADDR_W-1:0] pend_addr;
    logic              pend_we;
    logic [DW-1:0]     pend_wdata;
    logic [SB-1:0]     pend_strb;
    logic [IDX_W-1:0]  vic_q;
    logic              flushing_q;

    logic             hit;
    logic [IDX_W-1:0] hit_idx, lru_vic;
    logic             fl_found;
    logic [IDX_W-1:0] fl_idx;

    wire [TAG_W-1:0] req_tag  = req_addr[ADDR_W-1:OFF_W];
    wire [TAG_W-1:0] pend_tag = pend_addr[ADDR_W-1:OFF_W];
    wire idle_ok   = (state_q == ST_IDLE) && !flush_req && req_valid;
    wire hit_take  = idle_ok && hit;
    wire miss_take = idle_ok && !hit;
    wire wb_fire   = (state_q == ST_WB) && arr_cmd_ready;
    wire fill_done = (state_q == ST_FILL_WAIT) && arr_rsp_valid;
    wire vic_dirty = valid_q[lru_vic] && (dirty_q[lru_vic] != '0);

    // Access path shared by idle hits and replay after a fill.
    wire              acc_fire  = hit_take || (state_q == ST_REPLAY);
    wire              acc_rep   = (state_q == ST_REPLAY);
    wire [IDX_W-1:0]  acc_idx   = acc_rep ? vic_q : hit_idx;
    wire [ADDR_W-1:0] acc_addr  = acc_rep ? pend_addr : req_addr;
    wire              acc_we    = acc_rep ? pend_we : req_we;
    wire [DW-1:0]     acc_wdata = acc_rep ? pend_wdata : req_wdata;
    wire [SB-1:0]     acc_strb  = acc_rep ? pend_strb : req_strb;
    wire [OFF_W-1:0]  acc_off   = acc_addr[OFF_W-1:0];

    rbc_match #(.NBUF(NBUF), .TAG_W(TAG_W)) u_match (
        .valid  (valid_q),
        .tags   (tag_q),
        .lookup (req_tag),
        .hit    (hit),
        .hit_idx(hit_idx)
    );

    rbc_lru #(.NBUF(NBUF)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_en (acc_fire || fill_done),
        .touch_idx(acc_fire ? acc_idx : vic_q),
        .valid    (valid_q),
        .victim   (lru_vic)
    );

    always_comb begin
        fl_found = 1'b0;
        fl_idx   = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (valid_q[i] && dirty_q[i] != '0) begin
                fl_found = 1'b1;
                fl_idx   = IDX_W'(i);
            end
        end
    end

    logic [SEGB-1:0] vic_flat;
    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign vic_flat[w*DW +: DW] = data_q[vic_q][w];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_req)      state_d = ST_FL_SCAN;
                else if (miss_take) state_d = vic_dirty ? ST_WB : ST_FILL_REQ;
            end
            ST_WB:        if (arr_cmd_ready) state_d = flushing_q ? ST_FL_SCAN : ST_FILL_REQ;
            ST_FILL_REQ:  if (arr_cmd_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (arr_rsp_valid) state_d = ST_REPLAY;
            ST_REPLAY:    state_d = ST_IDLE;
            ST_FL_SCAN:   state_d = fl_found ? ST_WB : ST_FL_DONE;
            ST_FL_DONE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE) && !flush_req;
        arr_cmd_valid = (state_q == ST_WB) || (state_q == ST_FILL_REQ);
        arr_cmd_we    = (state_q == ST_WB);
        arr_cmd_tag   = (state_q == ST_WB) ? tag_q[vic_q] : pend_tag;
        arr_cmd_wdata = vic_flat;
        arr_cmd_wmask = (state_q == ST_WB) ? dirty_q[vic_q] : '0;
        flush_done    = (state_q == ST_FL_DONE);
    end

    // Control and bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q       <= '0;
            tag_q         <= '0;
            for (int i = 0; i < NBUF; i++) dirty_q[i] <= '0;
            pend_addr     <= '0;
            pend_we       <= 1'b0;
            pend_wdata    <= '0;
            pend_strb     <= '0;
            vic_q         <= '0;
            flushing_q    <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            wr_txn_count  <= '0;
            wr_word_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (miss_take) begin
                pend_addr  <= req_addr;
                pend_we    <= req_we;
                pend_wdata <= req_wdata;
                pend_strb  <= req_strb;
                vic_q      <= lru_vic;
                flushing_q <= 1'b0;
            end
            if (state_q == ST_FL_SCAN && fl_found) begin
                vic_q      <= fl_idx;
                flushing_q <= 1'b1;
            end
            if (wb_fire) begin
                dirty_q[vic_q] <= '0;
                wr_txn_count   <= wr_txn_count + 1'b1;
                wr_word_count  <= wr_word_count + CNT_W'($countones(dirty_q[vic_q]));
            end
            if (fill_done) begin
                valid_q[vic_q] <= 1'b1;
                tag_q[vic_q]   <= pend_tag;
                dirty_q[vic_q] <= '0;
            end
            if (acc_fire) begin
                if (acc_we) begin
                    if (acc_strb != '0) dirty_q[acc_idx][acc_off] <= 1'b1;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= data_q[acc_idx][acc_off];
                end
            end
        end
    end

    // Buffer storage
    always_ff @(posedge clk) begin
        if (fill_done) begin
            for (int w = 0; w < WORDS; w++) data_q[vic_q][w] <= arr_rsp_rdata[w*DW +: DW];
        end else if (acc_fire && acc_we) begin
            for (int b = 0; b < SB; b++) begin
                if (acc_strb[b]) data_q[acc_idx][acc_off][b*8 +: 8] <= acc_wdata[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/rbc_row_cache_chk.sv
module rbc_row_cache_chk #(
    parameter int WORDS = 8,
    parameter int TAG_W = 11,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_req,
    input logic             req_ready,
    input logic             flush_done,
    input logic             arr_cmd_valid,
    input logic             arr_cmd_ready,
    input logic             arr_cmd_we,
    input logic [TAG_W-1:0] arr_cmd_tag,
    input logic [WORDS-1:0] arr_cmd_wmask,
    input logic [CNT_W-1:0] wr_txn_count,
    input logic [CNT_W-1:0] wr_word_count
);

    wire wr_hs = arr_cmd_valid && arr_cmd_ready && arr_cmd_we;

    p_flush_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !req_ready);

    p_clean_never_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd_valid && arr_cmd_we) |-> (arr_cmd_wmask != '0));

    p_cmd_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd_valid && !arr_cmd_ready) |=>
            (arr_cmd_valid && $stable(arr_cmd_we) && $stable(arr_cmd_tag) && $stable(arr_cmd_wmask)));

    p_txn_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> (wr_txn_count == $past(wr_txn_count) + 1'b1));

    p_count_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hs |=> ($stable(wr_txn_count) && $stable(wr_word_count)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    p_busy_on_array_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_cmd_valid |-> !req_ready);

endmodule

bind rbc_row_cache rbc_row_cache_chk #(
    .WORDS(WORDS),
    .TAG_W(ROW_W + SEG_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_req    (flush_req),
    .req_ready    (req_ready),
    .flush_done   (flush_done),
    .arr_cmd_valid(arr_cmd_valid),
    .arr_cmd_ready(arr_cmd_ready),
    .arr_cmd_we   (arr_cmd_we),
    .arr_cmd_tag  (arr_cmd_tag),
    .arr_cmd_wmask(arr_cmd_wmask),
    .wr_txn_count (wr_txn_count),
    .wr_word_count(wr_word_count)
);

// File: tb/tb_rbc_row_cache.sv
`timescale 1ns/1ps
module tb_rbc_row_cache;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [13:0]  req_addr = '0;
    logic         req_we = 1'b0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_strb = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         flush_req = 1'b0;
    logic         flush_done;
    logic         arr_cmd_valid;
    logic         arr_cmd_ready = 1'b0;
    logic         arr_cmd_we;
    logic [10:0]  arr_cmd_tag;
    logic [255:0] arr_cmd_wdata;
    logic [7:0]   arr_cmd_wmask;
    logic         arr_rsp_valid = 1'b0;
    logic [255:0] arr_rsp_rdata = '0;
    logic [31:0]  wr_txn_count, wr_word_count;

    always #4 clk = ~clk;

    rbc_row_cache dut (.*);

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- array model ----------------
    logic [255:0] amem [int];
    logic [11:0]  cmd_log [$];
    logic [7:0]   last_mask = '0;
    int rd_cnt = 0, pend_cd = 0, stall_bad = 0;
    logic [10:0]  pend_tag = '0;
    logic         prev_stall = 1'b0;
    logic [11:0]  prev_cmd = '0;

    function automatic logic [31:0] init_word(input logic [10:0] t, input int w);
        return 32'hC0DE_0000 | ({21'd0, t} << 3) | 32'(w);
    endfunction

    function automatic logic [255:0] rd_seg(input logic [10:0] t);
        logic [255:0] s;
        if (amem.exists(int'(t))) return amem[int'(t)];
        for (int w = 0; w < 8; w++) s[w*32 +: 32] = init_word(t, w);
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            arr_cmd_ready <= 1'b0;
            arr_rsp_valid <= 1'b0;
        end else begin
            if (prev_stall && (!arr_cmd_valid || {arr_cmd_we, arr_cmd_tag} != prev_cmd)) stall_bad++;
            prev_stall = arr_cmd_valid && !arr_cmd_ready;
            prev_cmd   = {arr_cmd_we, arr_cmd_tag};
            arr_cmd_ready <= ~arr_cmd_ready;
            arr_rsp_valid <= 1'b0;
            if (pend_cd > 0) begin
                pend_cd--;
                if (pend_cd == 0) begin
                    arr_rsp_valid <= 1'b1;
                    arr_rsp_rdata <= rd_seg(pend_tag);
                end
            end
            if (arr_cmd_valid && arr_cmd_ready) begin
                cmd_log.push_back({arr_cmd_we, arr_cmd_tag});
                if (arr_cmd_we) begin
                    logic [255:0] s;
                    s = rd_seg(arr_cmd_tag);
                    for (int w = 0; w < 8; w++)
                        if (arr_cmd_wmask[w]) s[w*32 +: 32] = arr_cmd_wdata[w*32 +: 32];
                    amem[int'(arr_cmd_tag)] = s;
                    last_mask = arr_cmd_wmask;
                end else begin
                    rd_cnt++;
                    pend_tag = arr_cmd_tag;
                    pend_cd  = 3;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [31:0] shadow [int];
    logic [31:0] expq [$];
    int done_cnt = 0;

    function automatic logic [31:0] sh_rd(input logic [13:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return init_word(a[13:3], int'(a[2:0]));
    endfunction

    always @(negedge clk) begin
        if (rst_n && flush_done) done_cnt++;
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) chk(1'b0, "R2/R3 unexpected response", {32'd0, rsp_rdata}, 64'd0);
            else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(rsp_rdata == e, "R2/R3/R4 read data", {32'd0, rsp_rdata}, {32'd0, e});
            end
        end
    end

    task automatic do_req(input logic [13:0] a, input bit w, input logic [31:0] d, input logic [3:0] s);
        bit acc;
        req_addr = a; req_we = w; req_wdata = d; req_strb = s; req_valid = 1'b1;
        do begin
            acc = req_ready;
            @(posedge clk);
            if (!acc) @(negedge clk);
        end while (!acc);
        if (w) begin
            logic [31:0] v;
            v = sh_rd(a);
            for (int b = 0; b < 4; b++) if (s[b]) v[b*8 +: 8] = d[b*8 +: 8];
            shadow[int'(a)] = v;
        end else expq.push_back(sh_rd(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(req_ready && expq.size() == 0)) @(negedge clk);
    endtask

    function automatic logic [13:0] mk(input int row, input int seg, input int w);
        return {6'(row), 5'(seg), 3'(w)};
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_up();
    end

    localparam int RA = 1, SA = 0, RB = 1, SB_ = 1, RC = 2, SC = 5, RD = 3, SD = 31, RE = 4, SE = 2, RF = 5, SF = 7;

    initial begin
        int rc0, lg, d0;
        logic [10:0] ta, tb, td, tf;
        logic [255:0] sa;
        ta = {6'(RA), 5'(SA)}; tb = {6'(RB), 5'(SB_)}; td = {6'(RD), 5'(SD)}; tf = {6'(RF), 5'(SF)};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
        chk(!rsp_valid && !arr_cmd_valid && !flush_done, "R1 outputs idle",
            {61'd0, rsp_valid, arr_cmd_valid, flush_done}, 64'd0);
        chk(wr_txn_count == 0 && wr_word_count == 0, "R1 counters", {wr_txn_count, wr_word_count}, 64'd0);

        // R2 miss fetch
        do_req(mk(RA, SA, 2), 0, 0, 0);
        wait_idle();
        chk(rd_cnt == 1, "R2 one segment read", 64'(rd_cnt), 64'd1);
        chk(cmd_log[$] == {1'b0, ta}, "R2 fetched tag", {52'd0, cmd_log[$]}, {52'd0, 1'b0, ta});

        // R3 hit: no traffic, response next cycle
        do_req(mk(RA, SA, 5), 0, 0, 0);
        chk(rsp_valid == 1'b1, "R3 hit latency", {63'd0, rsp_valid}, 64'd1);
        wait_idle();
        chk(rd_cnt == 1, "R3 hit no array read", 64'(rd_cnt), 64'd1);

        do_req(mk(RB, SB_, 0), 0, 0, 0);
        do_req(mk(RC, SC, 0), 0, 0, 0);
        do_req(mk(RD, SD, 0), 0, 0, 0);
        do_req(mk(RA, SA, 0), 0, 0, 0);
        do_req(mk(RE, SE, 0), 0, 0, 0);
        wait_idle();
        chk(wr_txn_count == 0, "R5 clean eviction no write", 64'(wr_txn_count), 64'd0);
        rc0 = rd_cnt;
        do_req(mk(RA, SA, 1), 0, 0, 0);
        wait_idle();
        chk(rd_cnt == rc0, "R8 recent buffer kept", 64'(rd_cnt), 64'(rc0));
        do_req(mk(RB, SB_, 3), 0, 0, 0);
        wait_idle();
        chk(rd_cnt == rc0 + 1, "R8 LRU buffer evicted", 64'(rd_cnt), 64'(rc0 + 1));

        // R4/R6 merged writes on A
        for (int i = 1; i <= 5; i++) do_req(mk(RA, SA, 1), 1, 32'h1111_0000 * i, 4'hF);
        do_req(mk(RA, SA, 6), 1, 32'hFFFF_AAAA, 4'b0011);
        do_req(mk(RA, SA, 3), 1, 32'hDEAD_BEEF, 4'b0000);
        do_req(mk(RA, SA, 6), 0, 0, 0);
        do_req(mk(RA, SA, 3), 0, 0, 0);
        wait_idle();
        chk(wr_txn_count == 0, "R6 no write before eviction", 64'(wr_txn_count), 64'd0);
        do_req(mk(RE, SE, 0), 0, 0, 0);
        do_req(mk(RB, SB_, 0), 0, 0, 0);
        do_req(mk(RD, SD, 0), 0, 0, 0);
        do_req(mk(RF, SF, 0), 0, 0, 0);
        wait_idle();
        chk(wr_txn_count == 1, "R6/R12 one write txn", 64'(wr_txn_count), 64'd1);
        chk(wr_word_count == 2, "R7/R12 two words", 64'(wr_word_count), 64'd2);
        chk(last_mask == 8'h42, "R7 word mask", 64'(last_mask), 64'h42);
        lg = cmd_log.size();
        chk(cmd_log[lg-2] == {1'b1, ta} && cmd_log[lg-1] == {1'b0, tf}, "R9 writeback before fill",
            {40'd0, cmd_log[lg-2], cmd_log[lg-1]}, {40'd0, 1'b1, ta, 1'b0, tf});
        sa = rd_seg(ta);
        chk(sa[32 +: 32] == 32'h5555_0000, "R6 latest data written", 64'(sa[32 +: 32]), 64'h5555_0000);
        chk(sa[0 +: 32] == init_word(ta, 0) && sa[6*32 +: 32] == 32'hC0DE_AAAA, "R7/R4 unmasked words kept",
            {sa[0 +: 32], sa[6*32 +: 32]}, {init_word(ta, 0), 32'hC0DE_AAAA});
        do_req(mk(RA, SA, 1), 0, 0, 0);
        wait_idle();

        // R10 flush order: buffers 0=F 1=A 2=B 3=D
        do_req(mk(RD, SD, 0), 1, 32'h0D0D_0D0D, 4'hF);
        do_req(mk(RB, SB_, 0), 1, 32'h0B0B_0B0B, 4'hF);
        do_req(mk(RF, SF, 7), 1, 32'h0F0F_0F0F, 4'hF);
        wait_idle();
        lg = cmd_log.size();
        d0 = done_cnt;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        for (int i = 0; i < 200 && done_cnt == d0; i++) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10 done pulse", 64'(done_cnt), 64'(d0 + 1));
        chk(cmd_log.size() == lg + 3, "R10 three writebacks", 64'(cmd_log.size()), 64'(lg + 3));
        chk(cmd_log[lg] == {1'b1, tf} && cmd_log[lg+1] == {1'b1, tb} && cmd_log[lg+2] == {1'b1, td},
            "R10 ascending index order", {28'd0, cmd_log[lg], cmd_log[lg+1], cmd_log[lg+2]},
            {28'd0, 1'b1, tf, 1'b1, tb, 1'b1, td});
        chk(wr_txn_count == 4 && wr_word_count == 5, "R12 counters after flush",
            {wr_txn_count, wr_word_count}, {32'd4, 32'd5});
        lg = cmd_log.size();
        d0 = done_cnt;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        for (int i = 0; i < 50 && done_cnt == d0; i++) @(negedge clk);
        chk(done_cnt == d0 + 1 && cmd_log.size() == lg, "R10 empty flush",
            {32'(done_cnt), 32'(cmd_log.size())}, {32'(d0 + 1), 32'(lg)});

        // R11 flush and request in the same cycle
        wait_idle();
        d0 = done_cnt;
        req_addr = mk(RF, SF, 7); req_we = 1'b0; req_strb = '0; req_valid = 1'b1;
        flush_req = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R11 flush wins", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        flush_req = 1'b0;
        do_req(mk(RF, SF, 7), 0, 0, 0);
        wait_idle();
        chk(done_cnt == d0 + 1, "R11 flush completed", 64'(done_cnt), 64'(d0 + 1));

        chk(stall_bad == 0, "R13 command held while stalled", 64'(stall_bad), 64'd0);
        chk(expq.size() == 0, "R3 all responses seen", 64'(expq.size()), 64'd0);
        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule